// File: doc/BRIEF.md
# Right-Justified Serial Audio Receiver

This block takes a two-channel serial audio stream (a word-select line, a bit clock and a data line) and turns it into parallel 24-bit left and right samples with a one-cycle valid strobe. Words are right-justified: each channel's word ends on the last bit before the word-select line changes. The block keeps 16-bit or 24-bit words, chosen by a static input. A 16-bit word is sign-extended to 24 bits on output.

All logic runs on the master clock. The word-select, bit-clock and data inputs are assumed synchronous to it, and their edges are found by comparing each input with its value one cycle earlier. When the bit clock stops, the block makes its own bit strobes from the master clock. It counts master-clock cycles over each word-select period and derives the bit-clock rate from that count. Samples are only released when that count is one of the supported ratios.

Top module: `rj_audio_rx`

## Requirements
- R1: Data is MSB first. The word for a half-frame is the last N bit strobes before the word-select edge that ends the half, where N is 24 or 16. Earlier strobes in the same half do not affect the word.
- R2: `lrck_i` high marks the left half and low marks the right half. A frame runs from one rising edge of `lrck_i` to the next. When the rise that ends a frame is seen in cycle t, `left_o` and `right_o` change and `valid_o` is high for exactly cycle t+1. The outputs hold their values at all other times.
- R3: With `word24_i`=1 the word is 24 bits. With `word24_i`=0 the word is 16 bits and bit 15 is copied into output bits 23..16.
- R4: In external mode a bit is taken in the cycle where `sclk_i` is 1 and was 0 in the cycle before.
- R5: The block enters internal mode (`int_mode_o`=1) after IDLE_CYC master cycles in a row with no `sclk_i` rise. It leaves internal mode in the cycle after the next `sclk_i` rise.
- R6: The period ratio is the number of master cycles between two `lrck_i` rises. The supported ratios are 64, 96, 128, 192, 256, 384, 512, 768, 1024 and 1152. `ratio_err_o` becomes 1 after a period that is not supported and 0 after one that is. It changes only after an `lrck_i` rise.
- R7: In internal mode the bit strobe comes every ratio/B master cycles, counted from each `lrck_i` edge; the strobe falls in the last cycle of each bit window. B is set by the ratio and the word size:
  - ratios 64, 128, 256, 512 and 1024: B is 64 for 24-bit words and 32 for 16-bit words;
  - ratios 96, 192, 384 and 768: B is 48;
  - ratio 1152: B is 72.
- R8: In internal mode, a frame is released only if three conditions hold:
  - the period that frame ends is supported;
  - the period before it is also supported;
  - both periods give the same strobe spacing.
- R9: A frame during which the mode changes produces no `valid_o`. So does any frame before the first `lrck_i` rise after reset.
- R10: After reset, `left_o`, `right_o`, `valid_o`, `int_mode_o` and `ratio_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| word24_i | input | 1 | 1 = 24-bit words, 0 = 16-bit words |
| lrck_i | input | 1 | Word select, high = left half |
| sclk_i | input | 1 | External bit clock, sampled by mclk |
| sdata_i | input | 1 | Serial data |
| left_o | output | 24 | Left sample |
| right_o | output | 24 | Right sample |
| valid_o | output | 1 | One-cycle strobe marking a new sample pair |
| int_mode_o | output | 1 | 1 while bit strobes are made internally |
| ratio_err_o | output | 1 | Last measured period ratio is unsupported |

## Verification
The rising word-select edge does two things in the same cycle. It closes the ratio measurement of the period that just ended, and it decides whether the frame's words are released, and that decision uses the measurement closed in that very cycle. The bench forces the two to interact in internal mode. It inserts a 200-cycle frame between 256-cycle frames, then moves from ratio 256 to 1152. Each frame that is released or held back is then compared with R8: only frames whose own period and the period before both classify to the same spacing may appear. The error flag is read after each of these frames.

// File: rtl/rj_audio_pkg.sv
package rj_audio_pkg;

    localparam int CNT_W = 12;
    localparam int DIV_W = 6;

    typedef struct packed {
        logic             ok;
        logic [DIV_W-1:0] div;
    } ratio_cls_t;

    // Maps a measured master/word-select ratio to master cycles per bit.
    function automatic ratio_cls_t classify_ratio(input logic [CNT_W-1:0] r,
                                                  input logic wide);
        ratio_cls_t c;
        c.ok  = 1'b1;
        c.div = DIV_W'(1);
        case (r)
            CNT_W'(64):   c.div = wide ? DIV_W'(1)  : DIV_W'(2);
            CNT_W'(128):  c.div = wide ? DIV_W'(2)  : DIV_W'(4);
            CNT_W'(256):  c.div = wide ? DIV_W'(4)  : DIV_W'(8);
            CNT_W'(512):  c.div = wide ? DIV_W'(8)  : DIV_W'(16);
            CNT_W'(1024): c.div = wide ? DIV_W'(16) : DIV_W'(32);
            CNT_W'(96):   c.div = DIV_W'(2);
            CNT_W'(192):  c.div = DIV_W'(4);
            CNT_W'(384):  c.div = DIV_W'(8);
            CNT_W'(768):  c.div = DIV_W'(16);
            CNT_W'(1152): c.div = DIV_W'(16);
            default:      c.ok  = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rj_ratio_meter.sv
module rj_ratio_meter
    import rj_audio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lrck_rise_i,
    input  logic             wide_i,
    output logic             done_o,
    output logic             meas_ok_o,
    output logic [DIV_W-1:0] meas_div_o,
    output logic             ok_q_o,
    output logic [DIV_W-1:0] div_q_o,
    output logic             err_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             ok;
        logic             err;
        logic [DIV_W-1:0] div;
    } meter_t;

    meter_t     q, d;
    ratio_cls_t meas;

    always_comb begin
        meas   = classify_ratio(q.cnt, wide_i);
        done_o = lrck_rise_i & q.armed;
        d      = q;
        if (q.cnt != '1) d.cnt = q.cnt + 1'b1;
        if (lrck_rise_i) begin
            d.cnt   = CNT_W'(1);
            d.armed = 1'b1;
        end
        if (done_o) begin
            d.ok  = meas.ok;
            d.err = ~meas.ok;
            if (meas.ok) d.div = meas.div;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.div <= DIV_W'(1);
        end else begin
            q <= d;
        end
    end

    assign meas_ok_o  = meas.ok;
    assign meas_div_o = meas.div;
    assign ok_q_o     = q.ok;
    assign div_q_o    = q.div;
    assign err_o      = q.err;

    // R6: error flag moves only after a word-select rise
    a_r6_err_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.err) |-> $past(lrck_rise_i));

    // R7: spacing never becomes zero
    a_r7_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        q.div != '0);

endmodule

// File: rtl/rj_bit_timer.sv
module rj_bit_timer
    import rj_audio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lrck_edge_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] ph_q, ph_d, eff;

    always_comb begin
        eff    = lrck_edge_i ? '0 : ph_q;
        tick_o = (eff == div_i - 1'b1);
        ph_d   = tick_o ? '0 : eff + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

endmodule

// File: rtl/rj_sclk_watch.sv
module rj_sclk_watch #(
    parameter int IDLE_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_rise_i,
    output logic mode_o,
    output logic flip_o
);

    localparam int IW = $clog2(IDLE_CYC + 1);

    typedef struct packed {
        logic [IW-1:0] cnt;
        logic          mode;
    } watch_t;

    watch_t q, d;

    always_comb begin
        d = q;
        if (sclk_rise_i) begin
            d.cnt  = '0;
            d.mode = 1'b0;
        end else if (q.cnt != IW'(IDLE_CYC)) begin
            d.cnt = q.cnt + 1'b1;
            if (d.cnt == IW'(IDLE_CYC)) d.mode = 1'b1;
        end
        flip_o = d.mode ^ q.mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mode_o = q.mode;

    // R5: internal mode is never entered right after a bit-clock rise
    a_r5_enter_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.mode) |-> !$past(sclk_rise_i));

    // R5: a bit-clock rise ends internal mode
    a_r5_exit: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise_i |=> !q.mode);

endmodule

// File: rtl/rj_audio_rx.sv
module rj_audio_rx
    import rj_audio_pkg::*;
#(
    parameter int WORD_W   = 24,
    parameter int SHORT_W  = 16,
    parameter int IDLE_CYC = 64
) (
    input  logic              mclk,
    input  logic              rst_n,
    input  logic              word24_i,
    input  logic              lrck_i,
    input  logic              sclk_i,
    input  logic              sdata_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o,
    output logic              int_mode_o,
    output logic              ratio_err_o
);

    localparam int EXT_W = WORD_W - SHORT_W;

    typedef struct packed {
        logic              lrck;
        logic              sclk;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] left_hold;
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
        logic              valid;
        logic              frame_ok;
    } rx_t;

    rx_t q, d;

    logic             lrck_rise, lrck_fall, lrck_edge, sclk_rise;
    logic             strobe, tick, mode, flip, rel_ok;
    logic             done, meas_ok, ok_q;
    logic [DIV_W-1:0] meas_div, div_q;
    logic [WORD_W-1:0] base;

    function automatic logic [WORD_W-1:0] fit_word(input logic [WORD_W-1:0] raw,
                                                    input logic wide);
        if (wide) return raw;
        return {{EXT_W{raw[SHORT_W-1]}}, raw[SHORT_W-1:0]};
    endfunction

    assign lrck_rise = lrck_i & ~q.lrck;
    assign lrck_fall = ~lrck_i & q.lrck;
    assign lrck_edge = lrck_rise | lrck_fall;
    assign sclk_rise = sclk_i & ~q.sclk;

    rj_ratio_meter u_meter (
        .clk         (mclk),
        .rst_n       (rst_n),
        .lrck_rise_i (lrck_rise),
        .wide_i      (word24_i),
        .done_o      (done),
        .meas_ok_o   (meas_ok),
        .meas_div_o  (meas_div),
        .ok_q_o      (ok_q),
        .div_q_o     (div_q),
        .err_o       (ratio_err_o)
    );

    rj_bit_timer u_timer (
        .clk         (mclk),
        .rst_n       (rst_n),
        .lrck_edge_i (lrck_edge),
        .div_i       (div_q),
        .tick_o      (tick)
    );

    rj_sclk_watch #(.IDLE_CYC(IDLE_CYC)) u_watch (
        .clk         (mclk),
        .rst_n       (rst_n),
        .sclk_rise_i (sclk_rise),
        .mode_o      (mode),
        .flip_o      (flip)
    );

    always_comb begin
        strobe = sclk_rise | (mode & tick);
        rel_ok = ~mode | (done & meas_ok & ok_q & (meas_div == div_q));
        base   = lrck_edge ? '0 : q.sh;

        d       = q;
        d.lrck  = lrck_i;
        d.sclk  = sclk_i;
        d.valid = 1'b0;
        d.sh    = strobe ? {base[WORD_W-2:0], sdata_i} : base;

        if (lrck_fall && q.frame_ok) d.left_hold = fit_word(q.sh, word24_i);

        if (lrck_rise && q.frame_ok && rel_ok) begin
            d.left  = q.left_hold;
            d.right = fit_word(q.sh, word24_i);
            d.valid = 1'b1;
        end

        if (flip)           d.frame_ok = 1'b0;
        else if (lrck_rise) d.frame_ok = 1'b1;
    end

    always_ff @(posedge mclk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign left_o     = q.left;
    assign right_o    = q.right;
    assign valid_o    = q.valid;
    assign int_mode_o = mode;

    // R2: strobe lasts one cycle
    a_r2_single_pulse: assert property (@(posedge mclk) disable iff (!rst_n)
        q.valid |=> !q.valid);

    // R2: strobe follows a word-select rise
    a_r2_after_rise: assert property (@(posedge mclk) disable iff (!rst_n)
        q.valid |-> $past(lrck_rise));

    // R2: outputs only move with the strobe
    a_r2_hold_left: assert property (@(posedge mclk) disable iff (!rst_n)
        !$stable(q.left) |-> q.valid);

    a_r2_hold_right: assert property (@(posedge mclk) disable iff (!rst_n)
        !$stable(q.right) |-> q.valid);

    // R9: no release for a frame spanning a mode change
    a_r9_mode_flip: assert property (@(posedge mclk) disable iff (!rst_n)
        flip |=> !q.frame_ok);

endmodule

// File: tb/rj_audio_rx_test.sv
module rj_audio_rx_test;

    logic        mclk = 1'b0;
    logic        rst_n, word24_i, lrck_i, sclk_i, sdata_i;
    logic [23:0] left_o, right_o;
    logic        valid_o, int_mode_o, ratio_err_o;

    int n_chk = 0;
    int n_bad = 0;
    int rec_n = 0;
    logic [23:0] rec_l [16];
    logic [23:0] rec_r [16];
    logic [23:0] exp_l [8];
    logic [23:0] exp_r [8];

    always #10 mclk = ~mclk;

    rj_audio_rx uut (
        .mclk(mclk), .rst_n(rst_n), .word24_i(word24_i), .lrck_i(lrck_i),
        .sclk_i(sclk_i), .sdata_i(sdata_i), .left_o(left_o), .right_o(right_o),
        .valid_o(valid_o), .int_mode_o(int_mode_o), .ratio_err_o(ratio_err_o)
    );

    // wide, bits per half, half bit period, left, right
    localparam logic [60:0] VEC [5] = '{
        {1'b1, 8'd32, 4'd1, 24'h123456, 24'h89ABCD},
        {1'b1, 8'd24, 4'd2, 24'hFEDCBA, 24'h000001},
        {1'b0, 8'd16, 4'd2, 24'h007FFF, 24'h008001},
        {1'b0, 8'd24, 4'd2, 24'h001234, 24'h00FFFF},
        {1'b1, 8'd32, 4'd2, 24'h800000, 24'h7FFFFF}
    };

    always @(negedge mclk) begin
        if (rst_n && valid_o) begin
            if (rec_n < 16) begin
                rec_l[rec_n] = left_o;
                rec_r[rec_n] = right_o;
            end
            rec_n++;
        end
    end

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ext_half(input logic lvl, input logic wide, input int bits,
                            input int h, input logic [23:0] w);
        int width;
        width  = wide ? 24 : 16;
        lrck_i = lvl;
        for (int b = 0; b < bits; b++) begin
            int idx;
            idx     = bits - 1 - b;
            sclk_i  = 1'b0;
            sdata_i = (idx < width) ? w[idx] : 1'b1;
            repeat (h) @(negedge mclk);
            sclk_i = 1'b1;
            if (b == 0 && lvl) word24_i = wide;
            repeat (h) @(negedge mclk);
        end
    endtask

    task automatic int_half(input logic lvl, input int bits, input int dv,
                            input logic [23:0] w);
        lrck_i = lvl;
        for (int b = 0; b < bits; b++) begin
            int idx;
            idx     = bits - 1 - b;
            sdata_i = (idx < 24) ? w[idx] : 1'b1;
            repeat (dv) @(negedge mclk);
        end
    endtask

    task automatic int_frame(input int bits, input int dv,
                             input logic [23:0] l, input logic [23:0] r);
        int_half(1'b1, bits, dv, l);
        int_half(1'b0, bits, dv, r);
    endtask

    initial begin
        rst_n = 1'b0; word24_i = 1'b1; lrck_i = 1'b0; sclk_i = 1'b0; sdata_i = 1'b0;
        repeat (5) @(negedge mclk);
        check("R10 left", left_o, 24'h0);
        check("R10 right", right_o, 24'h0);
        check("R10 valid", {23'h0, valid_o}, 24'h0);
        check("R10 mode", {23'h0, int_mode_o}, 24'h0);
        check("R10 err", {23'h0, ratio_err_o}, 24'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge mclk);

        // R1 R3 R4: external bit clock vectors
        for (int i = 0; i < 5; i++) begin
            logic [60:0] v;
            v = VEC[i];
            exp_l[i] = v[60] ? v[47:24] : {{8{v[39]}}, v[39:24]};
            exp_r[i] = v[60] ? v[23:0]  : {{8{v[15]}}, v[15:0]};
            ext_half(1'b1, v[60], int'(v[59:52]), int'(v[51:48]), v[47:24]);
            ext_half(1'b0, v[60], int'(v[59:52]), int'(v[51:48]), v[23:0]);
        end
        lrck_i = 1'b1; sclk_i = 1'b0;
        repeat (4) @(negedge mclk);
        check("R6 err after 256 period", {23'h0, ratio_err_o}, 24'h0);

        // R5: bit clock stops
        lrck_i = 1'b0;
        repeat (100) @(negedge mclk);
        check("R5 internal entered", {23'h0, int_mode_o}, 24'h1);

        // R7 R8: internal strobes, ratio 256, 24-bit => 4 cycles per bit
        int_frame(32, 4, 24'h111111, 24'h222222);              // A: after 104-cycle gap
        check("R6 err after bad gap", {23'h0, ratio_err_o}, 24'h1);
        exp_l[5] = 24'hA5C3E1; exp_r[5] = 24'h0F1E2D;
        int_frame(32, 4, exp_l[5], exp_r[5]);                  // B: released
        check("R6 err cleared", {23'h0, ratio_err_o}, 24'h0);
        int_frame(25, 4, 24'h333333, 24'h444444);              // E: 200-cycle period
        check("R6 err before bad rise", {23'h0, ratio_err_o}, 24'h0);
        int_frame(32, 4, 24'h555555, 24'h666666);              // F: held back
        check("R6 err after 200 period", {23'h0, ratio_err_o}, 24'h1);
        exp_l[6] = 24'h13579B; exp_r[6] = 24'hECA864;
        int_frame(32, 4, exp_l[6], exp_r[6]);                  // G: released
        check("R6 err after recovery", {23'h0, ratio_err_o}, 24'h0);
        int_frame(36, 16, 24'h777777, 24'h888888);             // H: spacing changes
        exp_l[7] = 24'h2468AC; exp_r[7] = 24'hDB9753;
        int_frame(36, 16, exp_l[7], exp_r[7]);                 // I: 72 Fs released
        lrck_i = 1'b1;
        repeat (4) @(negedge mclk);

        sclk_i = 1'b1;
        repeat (2) @(negedge mclk);
        check("R5 external restored", {23'h0, int_mode_o}, 24'h0);

        check("R8 R9 released frame count", 24'(rec_n), 24'd8);
        for (int i = 0; i < 8; i++) begin
            string tag;
            tag = (i < 5) ? "R1 R2 R3 R4" : "R2 R7 R8";
            check($sformatf("%s left #%0d", tag, i), rec_l[i], exp_l[i]);
            check($sformatf("%s right #%0d", tag, i), rec_r[i], exp_r[i]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge mclk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule